// File: doc/BRIEF.md
# Vector Length Control Register Unit

This block holds the vector-length state that a vectorising front end consults before it unrolls a scalar instruction into a loop of element operations. The state is the maximum vector length, the current vector length, the sub-vector group size, and two pairs of loop offsets: element offsets for source and destination, and sub-element offsets for source and destination. All of it lives in one packed context word. The pipeline reaches the block through a one-request-per-cycle port with three operations: read, write from a register value, and write from a 5-bit immediate. Each request targets one of four registers. The block range-checks the written value, flags illegal values, and in the same cycle returns the value the instruction puts in its destination register.

Two rules set this block apart from an ordinary control register. A write of the vector length returns the new, clamped length rather than the old one. The packed context word stores lengths as value minus one. A trap input swaps the live context with a shadow copy kept for each privilege level, on both entry and return, so a handler runs in its own vector context. The loop sequencer reads the live offsets from dedicated outputs. It can write back updated offsets, which are clamped to the current lengths.

Top module: `vlen_csr_unit`

## Requirements
- R1: After reset the maximum length is XLEN (64), the length is 1, the group size is 1 and all four offsets are 0, so the context word reads 0x3F.
- R2: The req_op codes are 0 and 3 for read, 1 for register write and 2 for immediate write. The req_sel codes are 0 for maximum length, 1 for length, 2 for group size and 3 for context. A read returns the true length values, or for the context the packed image with maxlen-1 in [5:0], len-1 in [11:6], source offset in [17:12], destination offset in [23:18], group-1 in [25:24], source sub-offset in [27:26] and destination sub-offset in [29:28], with all higher bits zero. A read changes no state.
- R3: A register write of 0, or of a value above XLEN, to the maximum length or the length raises rsp_exc, returns 0 and leaves all state unchanged.
- R4: A legal length write sets the length to the smaller of the value and the maximum length, returns that new length, and clears both element offsets.
- R5: A legal maximum-length write stores the value and returns the old maximum. If the length is now above the new maximum it is reduced to it, and the element offsets are limited to the new length minus one.
- R6: Immediate writes to the maximum length, the length and the group size use immediate+1, so immediates 0 to 31 give 1 to 32. An immediate context write takes the zero-extended immediate as the packed image.
- R7: A group-size write of 0 or of any value above 4 raises rsp_exc, returns 0 and changes nothing. A legal one stores the value, returns the old group size, and limits both sub-offsets to the group size minus one.
- R8: A context write returns the old packed image. It stores the new one with the maximum limited to 1..XLEN, the length to 1..maximum, the element offsets to 0..length-1 and the sub-offsets to 0..group-1. Bits above 29 of the written value are ignored.
- R9: A trap pulse with a level below NLVL swaps the live context with that level's shadow copy. Each shadow resets to the R1 state. A level of NLVL or above has no effect.
- R10: A sequencer offset update takes effect when no trap and no request occur in the same cycle. Element offsets are limited to length-1 and sub-offsets to group-1, and the live offsets appear on the cur_* outputs.
- R11: A trap beats a request and a request beats a sequencer update. A request that meets a trap returns 0 with no exception and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_op | input | 2 | Operation code (R2) |
| req_sel | input | 2 | Target register code (R2) |
| req_wdata | input | XLEN | Value for register-form writes |
| req_imm | input | 5 | Immediate for immediate-form writes |
| rsp_rdata | output | XLEN | Destination-register value, same cycle as the request |
| rsp_exc | output | 1 | Illegal-value exception, same cycle as the request |
| trap_valid | input | 1 | Privilege change pulse (trap entry or return) |
| trap_level | input | clog2(NLVL) | Level whose shadow context is swapped |
| seq_valid | input | 1 | Sequencer offset update |
| seq_src | input | 6 | New source element offset |
| seq_dst | input | 6 | New destination element offset |
| seq_ssub | input | 2 | New source sub-offset |
| seq_dsub | input | 2 | New destination sub-offset |
| cur_maxlen | output | 7 | Live maximum length |
| cur_len | output | 7 | Live length |
| cur_sublen | output | 3 | Live group size |
| cur_src | output | 6 | Live source element offset |
| cur_dst | output | 6 | Live destination element offset |
| cur_ssub | output | 2 | Live source sub-offset |
| cur_dsub | output | 2 | Live destination sub-offset |

## Verification
The assertions check on every cycle that the length never exceeds the maximum and that every offset stays inside its length. They also check that an exception or a plain read leaves the context untouched, that an accepted length write clears the element offsets, and that a trap loads exactly the shadow slot it selected. Only the directed scenarios can show the returned values: the old value for the maximum, group size and context, and the new clamped value for the length. The same holds for the immediate+1 mapping, the exact clamp results after writes that shrink the lengths, and the round trip of a context through several nested privilege swaps.

// File: rtl/vlen_csr_pkg.sv
package vlen_csr_pkg;

    localparam int FW   = 6;   // element length/offset field width
    localparam int SW   = 2;   // group size/sub-offset field width
    localparam int LW   = FW + 1;
    localparam int SLW  = SW + 1;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WREG  = 2'd1,
        OP_WIMM  = 2'd2,
        OP_READX = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEL_MAXLEN = 2'd0,
        SEL_LEN    = 2'd1,
        SEL_SUBLEN = 2'd2,
        SEL_CTX    = 2'd3
    } sel_e;

    // Field order fixes the packed image bit positions, LSB last.
    typedef struct packed {
        logic [SW-1:0] dsub;
        logic [SW-1:0] ssub;
        logic [SW-1:0] sub_m1;
        logic [FW-1:0] dst;
        logic [FW-1:0] src;
        logic [FW-1:0] len_m1;
        logic [FW-1:0] max_m1;
    } ctx_t;

    localparam int CTXW = $bits(ctx_t);

endpackage

// File: rtl/vlen_ctx_clamp.sv
module vlen_ctx_clamp
    import vlen_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ctx_t raw_i,
    output ctx_t clean_o
);

    localparam logic [LW-1:0] LIMIT = LW'(XLEN);

    logic [LW-1:0] max_v;
    logic [LW-1:0] len_v;
    logic [LW-1:0] top_off;

    always_comb begin
        clean_o = raw_i;

        max_v = {1'b0, raw_i.max_m1} + LW'(1);
        if (max_v > LIMIT) begin
            max_v = LIMIT;
        end

        len_v = {1'b0, raw_i.len_m1} + LW'(1);
        if (len_v > max_v) begin
            len_v = max_v;
        end
        top_off = len_v - LW'(1);

        clean_o.max_m1 = FW'(max_v - LW'(1));
        clean_o.len_m1 = FW'(top_off);

        if ({1'b0, raw_i.src} > top_off) begin
            clean_o.src = FW'(top_off);
        end
        if ({1'b0, raw_i.dst} > top_off) begin
            clean_o.dst = FW'(top_off);
        end
        if (raw_i.ssub > raw_i.sub_m1) begin
            clean_o.ssub = raw_i.sub_m1;
        end
        if (raw_i.dsub > raw_i.sub_m1) begin
            clean_o.dsub = raw_i.sub_m1;
        end
    end

endmodule

// File: rtl/vlen_shadow_bank.sv
module vlen_shadow_bank
    import vlen_csr_pkg::*;
#(
    parameter int   NLVL    = 3,
    parameter int   LVLW    = 2,
    parameter ctx_t RST_CTX = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            swap_i,
    input  logic [LVLW-1:0] lvl_i,
    input  ctx_t            live_i,
    output ctx_t            shadow_o
);

    ctx_t slot_rd [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_slot
        ctx_t slot_d;
        ctx_t slot_q;

        always_comb begin
            slot_d = slot_q;
            if (swap_i && (lvl_i == LVLW'(g))) begin
                slot_d = live_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= RST_CTX;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slot_rd[g] = slot_q;
    end

    always_comb begin
        shadow_o = RST_CTX;
        for (int i = 0; i < NLVL; i++) begin
            if (lvl_i == LVLW'(i)) begin
                shadow_o = slot_rd[i];
            end
        end
    end

endmodule

// File: rtl/vlen_csr_unit.sv
module vlen_csr_unit
    import vlen_csr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NLVL = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [1:0]               req_op,
    input  logic [1:0]               req_sel,
    input  logic [XLEN-1:0]          req_wdata,
    input  logic [4:0]               req_imm,
    output logic [XLEN-1:0]          rsp_rdata,
    output logic                     rsp_exc,
    input  logic                     trap_valid,
    input  logic [$clog2(NLVL)-1:0]  trap_level,
    input  logic                     seq_valid,
    input  logic [FW-1:0]            seq_src,
    input  logic [FW-1:0]            seq_dst,
    input  logic [SW-1:0]            seq_ssub,
    input  logic [SW-1:0]            seq_dsub,
    output logic [LW-1:0]            cur_maxlen,
    output logic [LW-1:0]            cur_len,
    output logic [SLW-1:0]           cur_sublen,
    output logic [FW-1:0]            cur_src,
    output logic [FW-1:0]            cur_dst,
    output logic [SW-1:0]            cur_ssub,
    output logic [SW-1:0]            cur_dsub
);

    localparam int   LVLW    = $clog2(NLVL);
    localparam ctx_t RST_CTX = '{dsub: '0, ssub: '0, sub_m1: '0, dst: '0,
                                 src: '0, len_m1: '0, max_m1: FW'(XLEN - 1)};

    ctx_t            live_q;
    ctx_t            live_d;
    ctx_t            raw_c;
    ctx_t            shadow_c;
    logic            trap_act;
    logic            is_write;
    logic            wr_act;
    logic [XLEN-1:0] val_c;
    logic            len_bad;
    logic            sub_bad;
    logic [LW-1:0]   max_now;
    logic [LW-1:0]   len_now;
    logic [SLW-1:0]  sub_now;
    logic [LW-1:0]   new_len;

    assign trap_act = trap_valid && (trap_level < LVLW'(NLVL));
    assign is_write = (req_op == OP_WREG) || (req_op == OP_WIMM);
    assign wr_act   = req_valid && !trap_act && is_write;

    always_comb begin
        max_now = {1'b0, live_q.max_m1} + LW'(1);
        len_now = {1'b0, live_q.len_m1} + LW'(1);
        sub_now = {1'b0, live_q.sub_m1} + SLW'(1);

        val_c   = (req_op == OP_WIMM) ? (XLEN'(req_imm) + XLEN'(1)) : req_wdata;
        len_bad = (val_c == '0) || (val_c > XLEN'(XLEN));
        sub_bad = (val_c == '0) || (val_c > XLEN'(4));
        new_len = (LW'(val_c) > max_now) ? max_now : LW'(val_c);

        raw_c     = live_q;
        rsp_rdata = '0;
        rsp_exc   = 1'b0;

        if (trap_act) begin
            raw_c = shadow_c;
        end else if (req_valid) begin
            case (req_sel)
                SEL_MAXLEN: begin
                    rsp_rdata = XLEN'(max_now);
                    if (is_write) begin
                        if (len_bad) begin
                            rsp_exc   = 1'b1;
                            rsp_rdata = '0;
                        end else begin
                            raw_c.max_m1 = FW'(val_c - XLEN'(1));
                        end
                    end
                end
                SEL_LEN: begin
                    rsp_rdata = XLEN'(len_now);
                    if (is_write) begin
                        if (len_bad) begin
                            rsp_exc   = 1'b1;
                            rsp_rdata = '0;
                        end else begin
                            raw_c.len_m1 = FW'(new_len - LW'(1));
                            raw_c.src    = '0;
                            raw_c.dst    = '0;
                            rsp_rdata    = XLEN'(new_len);
                        end
                    end
                end
                SEL_SUBLEN: begin
                    rsp_rdata = XLEN'(sub_now);
                    if (is_write) begin
                        if (sub_bad) begin
                            rsp_exc   = 1'b1;
                            rsp_rdata = '0;
                        end else begin
                            raw_c.sub_m1 = SW'(val_c - XLEN'(1));
                        end
                    end
                end
                default: begin
                    rsp_rdata = XLEN'(live_q);
                    if (is_write) begin
                        raw_c = (req_op == OP_WIMM) ? ctx_t'(CTXW'(req_imm))
                                                    : ctx_t'(req_wdata[CTXW-1:0]);
                    end
                end
            endcase
        end else if (seq_valid) begin
            raw_c.src  = seq_src;
            raw_c.dst  = seq_dst;
            raw_c.ssub = seq_ssub;
            raw_c.dsub = seq_dsub;
        end
    end

    vlen_ctx_clamp #(
        .XLEN (XLEN)
    ) u_clamp (
        .raw_i   (raw_c),
        .clean_o (live_d)
    );

    vlen_shadow_bank #(
        .NLVL    (NLVL),
        .LVLW    (LVLW),
        .RST_CTX (RST_CTX)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_i   (trap_act),
        .lvl_i    (trap_level),
        .live_i   (live_q),
        .shadow_o (shadow_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= RST_CTX;
        end else begin
            live_q <= live_d;
        end
    end

    assign cur_maxlen = max_now;
    assign cur_len    = len_now;
    assign cur_sublen = sub_now;
    assign cur_src    = live_q.src;
    assign cur_dst    = live_q.dst;
    assign cur_ssub   = live_q.ssub;
    assign cur_dsub   = live_q.dsub;

    AST_LEN_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        live_q.len_m1 <= live_q.max_m1); // R8

    AST_OFFS_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q.src <= live_q.len_m1) && (live_q.dst <= live_q.len_m1) &&
        (live_q.ssub <= live_q.sub_m1) && (live_q.dsub <= live_q.sub_m1)); // R10

    AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc |=> $stable(live_q)); // R3

    AST_READ_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !trap_act && !is_write) |=> $stable(live_q)); // R2

    AST_LEN_WRITE_CLEARS_OFFS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && (req_sel == SEL_LEN) && !rsp_exc) |=>
        ((live_q.src == '0) && (live_q.dst == '0))); // R4

    AST_SWAP_LOADS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        trap_act |=> (live_q == $past(shadow_c))); // R9

endmodule

// File: tb/vlen_csr_unit_bench.sv
module vlen_csr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_sel = 2'd0;
    logic [63:0] req_wdata = '0;
    logic [4:0]  req_imm = '0;
    logic [63:0] rsp_rdata;
    logic        rsp_exc;
    logic        trap_valid = 1'b0;
    logic [1:0]  trap_level = 2'd0;
    logic        seq_valid = 1'b0;
    logic [5:0]  seq_src = '0;
    logic [5:0]  seq_dst = '0;
    logic [1:0]  seq_ssub = '0;
    logic [1:0]  seq_dsub = '0;
    logic [6:0]  cur_maxlen;
    logic [6:0]  cur_len;
    logic [2:0]  cur_sublen;
    logic [5:0]  cur_src;
    logic [5:0]  cur_dst;
    logic [1:0]  cur_ssub;
    logic [1:0]  cur_dsub;

    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [63:0] cap_data;
    logic        cap_exc;

    always #5 clk = ~clk;

    vlen_csr_unit u_vlen_csr_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_sel(req_sel),
        .req_wdata(req_wdata), .req_imm(req_imm),
        .rsp_rdata(rsp_rdata), .rsp_exc(rsp_exc),
        .trap_valid(trap_valid), .trap_level(trap_level),
        .seq_valid(seq_valid), .seq_src(seq_src), .seq_dst(seq_dst),
        .seq_ssub(seq_ssub), .seq_dsub(seq_dsub),
        .cur_maxlen(cur_maxlen), .cur_len(cur_len), .cur_sublen(cur_sublen),
        .cur_src(cur_src), .cur_dst(cur_dst), .cur_ssub(cur_ssub), .cur_dsub(cur_dsub)
    );

    function automatic logic [63:0] pk(input int mx, input int ln, input int s, input int d,
                                       input int sb, input int ss, input int ds);
        logic [63:0] v;
        v = 64'(mx & 63) | (64'(ln & 63) << 6) | (64'(s & 63) << 12) | (64'(d & 63) << 18) |
            (64'(sb & 3) << 24) | (64'(ss & 3) << 26) | (64'(ds & 3) << 28);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic tv, input logic [1:0] tl, input logic rv,
                        input logic [1:0] op, input logic [1:0] sel, input logic [63:0] wd,
                        input logic [4:0] im, input logic sv, input logic [5:0] s,
                        input logic [5:0] d, input logic [1:0] ss, input logic [1:0] ds);
        @(negedge clk);
        trap_valid = tv; trap_level = tl;
        req_valid = rv; req_op = op; req_sel = sel; req_wdata = wd; req_imm = im;
        seq_valid = sv; seq_src = s; seq_dst = d; seq_ssub = ss; seq_dsub = ds;
        #1;
        cap_data = rsp_rdata;
        cap_exc  = rsp_exc;
        @(posedge clk);
        #1;
        trap_valid = 1'b0; req_valid = 1'b0; seq_valid = 1'b0;
    endtask

    task automatic csr(input logic [1:0] op, input logic [1:0] sel, input logic [63:0] wd,
                       input logic [4:0] im);
        step(1'b0, 2'd0, 1'b1, op, sel, wd, im, 1'b0, 6'd0, 6'd0, 2'd0, 2'd0);
    endtask

    task automatic seq(input logic [5:0] s, input logic [5:0] d, input logic [1:0] ss,
                       input logic [1:0] ds);
        step(1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 64'd0, 5'd0, 1'b1, s, d, ss, ds);
    endtask

    task automatic trap(input logic [1:0] lvl);
        step(1'b1, lvl, 1'b0, 2'd0, 2'd0, 64'd0, 5'd0, 1'b0, 6'd0, 6'd0, 2'd0, 2'd0);
    endtask

    task automatic t_reset;
        chk("R1 maxlen", 64'(cur_maxlen), 64);
        chk("R1 len", 64'(cur_len), 1);
        chk("R1 sublen", 64'(cur_sublen), 1);
        chk("R1 offsets", 64'({cur_src, cur_dst, cur_ssub, cur_dsub}), 0);
        csr(2'd0, 2'd3, 64'd0, 5'd0);
        chk("R1 ctx image", cap_data, 64'h3F);
        csr(2'd0, 2'd0, 64'd0, 5'd0);
        chk("R2 read maxlen", cap_data, 64);
        csr(2'd3, 2'd1, 64'd0, 5'd0);
        chk("R2 read len op3", cap_data, 1);
        chk("R2 read no change", 64'(cur_len), 1);
    endtask

    task automatic t_len;
        csr(2'd1, 2'd1, 64'd10, 5'd0);
        chk("R4 len rd", cap_data, 10);
        chk("R4 len exc", 64'(cap_exc), 0);
        chk("R4 len state", 64'(cur_len), 10);
        csr(2'd1, 2'd1, 64'd100, 5'd0);
        chk("R3 len 100 exc", 64'(cap_exc), 1);
        chk("R3 len 100 rd", cap_data, 0);
        chk("R3 len 100 kept", 64'(cur_len), 10);
        csr(2'd1, 2'd1, 64'd0, 5'd0);
        chk("R3 len 0 exc", 64'(cap_exc), 1);
        csr(2'd1, 2'd1, 64'd65, 5'd0);
        chk("R3 len 65 exc", 64'(cap_exc), 1);
        csr(2'd1, 2'd1, 64'd64, 5'd0);
        chk("R4 len 64 rd", cap_data, 64);
        chk("R4 len 64 exc", 64'(cap_exc), 0);
    endtask

    task automatic t_max;
        seq(6'd20, 6'd7, 2'd0, 2'd0);
        chk("R10 seq src", 64'(cur_src), 20);
        chk("R10 seq dst", 64'(cur_dst), 7);
        csr(2'd1, 2'd0, 64'd8, 5'd0);
        chk("R5 max rd old", cap_data, 64);
        chk("R5 max state", 64'(cur_maxlen), 8);
        chk("R5 len shrunk", 64'(cur_len), 8);
        chk("R5 src limited", 64'(cur_src), 7);
        chk("R5 dst kept", 64'(cur_dst), 7);
        csr(2'd1, 2'd1, 64'd20, 5'd0);
        chk("R4 len min rd", cap_data, 8);
        chk("R4 offs cleared", 64'({cur_src, cur_dst}), 0);
        csr(2'd1, 2'd0, 64'd0, 5'd0);
        chk("R3 max 0 exc", 64'(cap_exc), 1);
        chk("R3 max 0 kept", 64'(cur_maxlen), 8);
        csr(2'd1, 2'd0, 64'd64, 5'd0);
        chk("R5 max back rd", cap_data, 8);
        chk("R5 len kept", 64'(cur_len), 8);
    endtask

    task automatic t_imm;
        csr(2'd2, 2'd1, 64'd0, 5'd31);
        chk("R6 imm len rd", cap_data, 32);
        chk("R6 imm len state", 64'(cur_len), 32);
        csr(2'd2, 2'd0, 64'd0, 5'd0);
        chk("R6 imm max rd", cap_data, 64);
        chk("R6 imm max 1", 64'(cur_maxlen), 1);
        chk("R6 imm max len", 64'(cur_len), 1);
        csr(2'd2, 2'd0, 64'd0, 5'd31);
        chk("R6 imm max 32", 64'(cur_maxlen), 32);
        csr(2'd2, 2'd2, 64'd0, 5'd3);
        chk("R6 imm sub rd", cap_data, 1);
        chk("R6 imm sub 4", 64'(cur_sublen), 4);
        csr(2'd2, 2'd2, 64'd0, 5'd4);
        chk("R7 imm sub 5 exc", 64'(cap_exc), 1);
        chk("R7 imm sub kept", 64'(cur_sublen), 4);
        csr(2'd2, 2'd3, 64'd0, 5'd5);
        chk("R6 imm ctx rd", cap_data, pk(31, 0, 0, 0, 3, 0, 0));
        chk("R6 imm ctx max", 64'(cur_maxlen), 6);
        chk("R6 imm ctx sub", 64'(cur_sublen), 1);
    endtask

    task automatic t_sub;
        csr(2'd1, 2'd2, 64'd0, 5'd0);
        chk("R7 sub 0 exc", 64'(cap_exc), 1);
        csr(2'd1, 2'd2, 64'd5, 5'd0);
        chk("R7 sub 5 exc", 64'(cap_exc), 1);
        chk("R7 sub 5 rd", cap_data, 0);
        csr(2'd1, 2'd2, 64'd3, 5'd0);
        chk("R7 sub rd old", cap_data, 1);
        chk("R7 sub state", 64'(cur_sublen), 3);
        seq(6'd0, 6'd0, 2'd3, 2'd1);
        chk("R10 ssub limited", 64'(cur_ssub), 2);
        chk("R10 dsub kept", 64'(cur_dsub), 1);
        csr(2'd1, 2'd2, 64'd1, 5'd0);
        chk("R7 shrink rd", cap_data, 3);
        chk("R7 sub offs limited", 64'({cur_ssub, cur_dsub}), 0);
    endtask

    task automatic t_ctx;
        csr(2'd1, 2'd3, pk(15, 20, 30, 4, 1, 3, 0) | (64'd1 << 40), 5'd0);
        chk("R8 ctx rd old", cap_data, pk(5, 0, 0, 0, 0, 0, 0));
        chk("R8 ctx max", 64'(cur_maxlen), 16);
        chk("R8 ctx len", 64'(cur_len), 16);
        chk("R8 ctx src", 64'(cur_src), 15);
        chk("R8 ctx dst", 64'(cur_dst), 4);
        chk("R8 ctx sub", 64'(cur_sublen), 2);
        chk("R8 ctx ssub", 64'(cur_ssub), 1);
        csr(2'd0, 2'd3, 64'd0, 5'd0);
        chk("R8 ctx readback", cap_data, pk(15, 15, 15, 4, 1, 1, 0));
    endtask

    task automatic t_seq;
        seq(6'd3, 6'd9, 2'd1, 2'd1);
        chk("R10 seq src", 64'(cur_src), 3);
        chk("R10 seq dst", 64'(cur_dst), 9);
        chk("R10 seq subs", 64'({cur_ssub, cur_dsub}), 4'b0101);
        seq(6'd40, 6'd2, 2'd0, 2'd0);
        chk("R10 seq src limited", 64'(cur_src), 15);
        chk("R10 seq dst", 64'(cur_dst), 2);
        step(1'b0, 2'd0, 1'b1, 2'd0, 2'd0, 64'd0, 5'd0, 1'b1, 6'd1, 6'd1, 2'd0, 2'd0);
        chk("R11 req rd", cap_data, 16);
        chk("R11 seq dropped", 64'(cur_src), 15);
    endtask

    task automatic t_trap;
        trap(2'd1);
        chk("R9 enter1 max", 64'(cur_maxlen), 64);
        chk("R9 enter1 len", 64'(cur_len), 1);
        csr(2'd1, 2'd1, 64'd5, 5'd0);
        chk("R9 handler len", 64'(cur_len), 5);
        trap(2'd2);
        chk("R9 enter2 len", 64'(cur_len), 1);
        trap(2'd2);
        chk("R9 leave2 len", 64'(cur_len), 5);
        trap(2'd1);
        chk("R9 leave1 len", 64'(cur_len), 16);
        chk("R9 leave1 src", 64'(cur_src), 15);
        chk("R9 leave1 sub", 64'(cur_sublen), 2);
        trap(2'd3);
        chk("R9 bad level ignored", 64'(cur_len), 16);
        step(1'b1, 2'd2, 1'b1, 2'd1, 2'd1, 64'd7, 5'd0, 1'b0, 6'd0, 6'd0, 2'd0, 2'd0);
        chk("R11 trap req rd", cap_data, 0);
        chk("R11 trap req exc", 64'(cap_exc), 0);
        chk("R11 trap wins", 64'(cur_len), 1);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #1;
        t_reset();
        t_len();
        t_max();
        t_imm();
        t_sub();
        t_ctx();
        t_seq();
        t_trap();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule